// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Control Sequencer

This block is the digital control core of a synchronous buck power stage. It receives a PWM command that an analog front end has already sorted into one of three levels (low, high, or a middle "floating" level). From that command it produces two registered gate commands, one for the high-side switch and one for the low-side switch. The two commands never overlap. A gate is switched on only after the feedback shows the opposite gate is low and a fixed number of clock cycles has also passed.

Four conditions override the PWM command. A middle level held for a programmable hold-off window turns both gates off. An active-low skip input blanks the low side, giving diode-emulation operation at light load. An active-low enable, or a deasserted supply-good flag, forces both gates off. Each time the combined enable condition rises, the block first fires a short low-side pulse to recharge the bootstrap supply, and only then starts to follow the PWM command.

All time intervals are counted in cycles of the reference clock: the hold-off window, the precharge pulse and the fixed dead time.

Top module: `hb_gate_seq`

## Requirements
- R1: A synchronous active-high reset clears both gate commands. After reset the block stays idle, with both gates off, until it sees a 0-to-1 transition of the combined enable condition (drive_en AND supply_ok). Holding drive_en high through reset does not count as such a transition.
- R2: pwm_code is decoded as 2'b00 = low, 2'b01 = high, and 2'b10 or 2'b11 = middle. While the block is tracking, a high code requests the high-side gate only and a low code requests the low-side gate only.
- R3: A gate command rises only on a clock edge where three conditions hold: the opposite command is off, the opposite gate-low feedback is 1, and that same condition has held on DEAD_CYC earlier consecutive edges. If the feedback never arrives, the block waits without limit.
- R4: hs_on and ls_on are never both 1.
- R5: Once a middle code has been seen on HOLD_CYC consecutive edges, both gates are off after that edge. A middle run shorter than this keeps the last low or high request. The run counter restarts whenever the code leaves the middle region.
- R6: While sync_rect is 0, ls_on is 0 after every edge, including during precharge. A high code still turns the high side on.
- R7: drive_en sampled 0 forces both commands to 0 at that edge, whatever the other inputs are.
- R8: After a 0-to-1 transition of the enable condition, the low side is requested for exactly PRE_CYC cycles and PWM tracking starts after that. The precharge is aborted if the enable condition falls during it.
- R9: supply_ok sampled 0 forces both commands to 0 at that edge. When the supply recovers with drive_en high, this counts as an enable transition and starts a new precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_code | input | 2 | Classified PWM level: 00 low, 01 high, 1x middle |
| drive_en | input | 1 | Active-low disable; 0 forces both gates off |
| sync_rect | input | 1 | 0 blanks the low side (diode emulation) |
| supply_ok | input | 1 | Supply-good flag from the undervoltage monitor |
| hs_off_fb | input | 1 | 1 when the high-side gate is sensed low |
| ls_off_fb | input | 1 | 1 when the low-side gate is sensed low |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |

## Verification
The assertions assume two things about the inputs. First, every input is a clean synchronous level that holds steady around the clock edge. Second, a gate-low feedback bit may lag its command or stick at 0, but is never X.

The stimulus changes inputs only on the falling clock edge. The bench generates gate-low feedback from the outputs through a two-cycle delay, and can force either feedback bit stuck at 0 to exercise the unbounded wait. Random PWM codes, enable drops, supply dips and skip-mode changes are weighted so that middle runs both shorter and longer than the hold-off window occur.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [1:0] {
    LVL_OFF = 2'd0,
    LVL_HI  = 2'd1,
    LVL_LO  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  localparam logic [1:0] CODE_LO = 2'b00;
  localparam logic [1:0] CODE_HI = 2'b01;

endpackage

// File: rtl/hbs_holdoff.sv
module hbs_holdoff
  import hbs_pkg::*;
#(
  parameter int HOLD_CYC = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] code_i,
  output lvl_e       lvl_o
);

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYC - 1);

  logic [CW-1:0] mid_q;
  lvl_e          last_q;
  logic          is_mid;

  assign is_mid = (code_i != CODE_LO) && (code_i != CODE_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q  <= '0;
      last_q <= LVL_OFF;
    end else begin
      if (is_mid) mid_q <= (mid_q >= LIM) ? LIM : mid_q + CW'(1);
      else        mid_q <= '0;
      if (code_i == CODE_HI)      last_q <= LVL_HI;
      else if (code_i == CODE_LO) last_q <= LVL_LO;
    end
  end

  always_comb begin
    if (code_i == CODE_HI)      lvl_o = LVL_HI;
    else if (code_i == CODE_LO) lvl_o = LVL_LO;
    else if (mid_q >= LIM)      lvl_o = LVL_OFF;
    else                        lvl_o = last_q;
  end

  // R5: the run counter clears as soon as the code leaves the middle region
  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    !is_mid |=> (mid_q == '0));

endmodule

// File: rtl/hbs_enable_seq.sv
module hbs_enable_seq
  import hbs_pkg::*;
#(
  parameter int PRE_CYC = 6
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   act_i,
  output phase_e phase_o
);

  localparam int PW = $clog2(PRE_CYC + 1);
  localparam logic [PW-1:0] PLAST = PW'(PRE_CYC - 1);

  phase_e        phase_q;
  logic [PW-1:0] pc_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pc_q    <= '0;
      act_q   <= 1'b1;
    end else begin
      act_q <= act_i;
      if (!act_i) begin
        phase_q <= PH_IDLE;
        pc_q    <= '0;
      end else begin
        case (phase_q)
          PH_IDLE: if (!act_q) begin
            phase_q <= PH_PRE;
            pc_q    <= '0;
          end
          PH_PRE: begin
            if (pc_q == PLAST) phase_q <= PH_RUN;
            else               pc_q    <= pc_q + PW'(1);
          end
          default: phase_q <= PH_RUN;
        endcase
      end
    end
  end

  assign phase_o = phase_q;

  // R8: losing the enable condition always returns to idle
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    !act_i |=> (phase_q == PH_IDLE));

  // R1: leaving idle needs the enable condition to have been low the edge before
  a_r1_edge_only: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && act_q) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/hbs_gate_arb.sv
module hbs_gate_arb
  import hbs_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  lvl_e req_i,
  input  logic hs_off_fb,
  input  logic ls_off_fb,
  output logic hs_on,
  output logic ls_on
);

  localparam int DW = $clog2(DEAD_CYC + 2);
  localparam logic [DW-1:0] DLIM = DW'(DEAD_CYC);

  logic [1:0] want;
  logic [1:0] fb;
  logic [1:0] cmd_q;
  logic [1:0] cmd_d;

  assign want[0] = (req_i == LVL_HI);
  assign want[1] = (req_i == LVL_LO);
  assign fb      = {ls_off_fb, hs_off_fb};

  // index 0 = high side, index 1 = low side
  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int O = 1 - s;
    logic [DW-1:0] wait_q;
    logic          blocked;
    logic          go;

    assign blocked = cmd_q[O] || !fb[O];
    assign go      = !blocked && (wait_q >= DLIM);
    assign cmd_d[s] = want[s] && (cmd_q[s] || go);

    always_ff @(posedge clk) begin
      if (rst)          wait_q <= '0;
      else if (blocked) wait_q <= '0;
      else if (wait_q < DLIM) wait_q <= wait_q + DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= 2'b00;
    else     cmd_q <= cmd_d;
  end

  assign hs_on = cmd_q[0];
  assign ls_on = cmd_q[1];

  // R4: no overlap of the two commands
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on));

  // R3: high side rises only after low side was off and sensed low
  a_r3_hs_after_fb: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> ($past(ls_off_fb) && !$past(ls_on)));

  // R3: low side rises only after high side was off and sensed low
  a_r3_ls_after_fb: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_on) |-> ($past(hs_off_fb) && !$past(hs_on)));

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hbs_pkg::*;
#(
  parameter int HOLD_CYC = 13,
  parameter int PRE_CYC  = 6,
  parameter int DEAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwm_code,
  input  logic       drive_en,
  input  logic       sync_rect,
  input  logic       supply_ok,
  input  logic       hs_off_fb,
  input  logic       ls_off_fb,
  output logic       hs_on,
  output logic       ls_on
);

  logic   act;
  lvl_e   lvl;
  lvl_e   req;
  phase_e phase;

  assign act = drive_en && supply_ok;

  hbs_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .code_i(pwm_code), .lvl_o(lvl)
  );

  hbs_enable_seq #(.PRE_CYC(PRE_CYC)) u_ena (
    .clk(clk), .rst(rst), .act_i(act), .phase_o(phase)
  );

  always_comb begin
    case (phase)
      PH_PRE:  req = LVL_LO;
      PH_RUN:  req = lvl;
      default: req = LVL_OFF;
    endcase
    if (!act) req = LVL_OFF;
    if (!sync_rect && req == LVL_LO) req = LVL_OFF;
  end

  hbs_gate_arb #(.DEAD_CYC(DEAD_CYC)) u_arb (
    .clk(clk), .rst(rst), .req_i(req),
    .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  // R7: disable forces both gates off at the sampling edge
  a_r7_disable_off: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> (!hs_on && !ls_on));

  // R9: loss of supply clamps both gates
  a_r9_supply_off: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!hs_on && !ls_on));

  // R6: skip mode blanks the low side
  a_r6_ls_blank: assert property (@(posedge clk) disable iff (rst)
    !sync_rect |=> !ls_on);

endmodule

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;

  localparam int CLK_P = 10;
  localparam int HOLD  = 13;
  localparam int PRE   = 6;
  localparam int DEAD  = 2;
  localparam logic [1:0] C_LO  = 2'b00;
  localparam logic [1:0] C_HI  = 2'b01;
  localparam logic [1:0] C_MID = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] code = C_MID;
  logic en = 1'b0, sr = 1'b1, ok = 1'b1;
  logic hs_stuck = 1'b0, ls_stuck = 1'b0;
  logic [1:0] hs_pipe = 2'b00, ls_pipe = 2'b00;
  logic hs_fb, ls_fb, hs_on, ls_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  assign hs_fb = !hs_pipe[1] && !hs_stuck;
  assign ls_fb = !ls_pipe[1] && !ls_stuck;

  hb_gate_seq #(.HOLD_CYC(HOLD), .PRE_CYC(PRE), .DEAD_CYC(DEAD)) u0 (
    .clk(clk), .rst(rst), .pwm_code(code), .drive_en(en), .sync_rect(sr),
    .supply_ok(ok), .hs_off_fb(hs_fb), .ls_off_fb(ls_fb),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  // gate feedback model: two-cycle lag from command to sensed level
  always @(negedge clk) begin
    hs_pipe <= {hs_pipe[0], hs_on};
    ls_pipe <= {ls_pipe[0], ls_on};
  end

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Expected-value model built from R1..R9
  bit m_hs, m_ls, m_actp, m_act;
  int m_ph, m_pc, m_mid, m_last, m_hw, m_lw, m_lvl, m_req;
  bit m_hgo, m_lgo, m_nh, m_nl;

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hs = 0; m_ls = 0; m_ph = 0; m_pc = 0; m_actp = 1;
      m_mid = 0; m_last = 0; m_hw = 0; m_lw = 0;
    end else begin
      m_act = en && ok;
      if (code == C_HI)             m_lvl = 1;
      else if (code == C_LO)        m_lvl = 2;
      else if (m_mid >= HOLD - 1)   m_lvl = 0;
      else                          m_lvl = m_last;
      m_req = (m_ph == 1) ? 2 : (m_ph == 2) ? m_lvl : 0;
      if (!m_act) m_req = 0;
      if (!sr && m_req == 2) m_req = 0;
      m_hgo = !m_ls && ls_fb && (m_hw >= DEAD);
      m_lgo = !m_hs && hs_fb && (m_lw >= DEAD);
      m_nh = (m_req == 1) && (m_hs || m_hgo);
      m_nl = (m_req == 2) && (m_ls || m_lgo);
      m_hw = (!m_ls && ls_fb) ? sat(m_hw + 1, DEAD) : 0;
      m_lw = (!m_hs && hs_fb) ? sat(m_lw + 1, DEAD) : 0;
      m_mid = (code != C_HI && code != C_LO) ? sat(m_mid + 1, HOLD - 1) : 0;
      if (code == C_HI) m_last = 1;
      else if (code == C_LO) m_last = 2;
      if (!m_act) begin m_ph = 0; m_pc = 0; end
      else if (m_ph == 0) begin if (!m_actp) begin m_ph = 1; m_pc = 0; end end
      else if (m_ph == 1) begin if (m_pc == PRE - 1) m_ph = 2; else m_pc++; end
      m_actp = m_act;
      m_hs = m_nh; m_ls = m_nl;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R3 model hs_on", hs_on, m_hs);
      check("R3 model ls_on", ls_on, m_ls);
      check("R4 overlap", hs_on && ls_on, 1'b0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_ls(input int n, output int cl, output int ch);
    cl = 0; ch = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cl += int'(ls_on);
      ch += int'(hs_on);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int cl, ch;
    bit ok_flag;
    void'($urandom(32'd4242));
    // R1: enable held high across reset gives no start
    rst = 1; en = 1; code = C_HI;
    step(4); rst = 0;
    step(20);
    check("R1 hs after reset", hs_on, 1'b0);
    check("R1 ls after reset", ls_on, 1'b0);

    // R8: rising enable gives a precharge pulse of PRE cycles
    en = 0; code = C_MID; step(20);
    en = 1;
    count_ls(30, cl, ch);
    check_int("R8 precharge length", cl, PRE);
    check_int("R8 no high side", ch, 0);

    // R2: tracking
    code = C_HI; step(12);
    check("R2 hs on high", hs_on, 1'b1);
    check("R2 ls off high", ls_on, 1'b0);
    code = C_LO; step(12);
    check("R2 ls on low", ls_on, 1'b1);
    check("R2 hs off low", hs_on, 1'b0);

    // R5: short middle run keeps state, full run turns off (2'b11 is middle)
    code = C_MID; ok_flag = 1;
    for (int i = 0; i < HOLD - 1; i++) begin
      step(1);
      if (!ls_on) ok_flag = 0;
    end
    check("R5 short mid keeps ls", ok_flag, 1'b1);
    code = C_LO; step(3);
    code = 2'b11; step(HOLD - 1);
    check("R5 ls before hold-off", ls_on, 1'b1);
    step(1);
    check("R5 ls after hold-off", ls_on, 1'b0);
    check("R5 hs after hold-off", hs_on, 1'b0);

    // R3: missing feedback makes the turn-on wait
    ls_stuck = 1; code = C_HI; step(40);
    check("R3 hs waits for feedback", hs_on, 1'b0);
    ls_stuck = 0; step(10);
    check("R3 hs after feedback", hs_on, 1'b1);

    // R6: skip mode
    sr = 0; code = C_LO; step(15);
    check("R6 ls blank", ls_on, 1'b0);
    check("R6 hs off on low", hs_on, 1'b0);
    code = C_HI; step(12);
    check("R6 hs still works", hs_on, 1'b1);

    // R7: disable
    en = 0; step(1);
    check("R7 hs off", hs_on, 1'b0);
    check("R7 ls off", ls_on, 1'b0);

    // R6: no precharge pulse in skip mode
    code = C_MID; step(15); en = 1;
    count_ls(30, cl, ch);
    check_int("R6 precharge blanked", cl, 0);
    sr = 1;

    // R9: supply loss and recovery
    code = C_HI; step(15);
    check("R9 hs before dip", hs_on, 1'b1);
    ok = 0; step(1);
    check("R9 hs clamped", hs_on, 1'b0);
    check("R9 ls clamped", ls_on, 1'b0);
    step(5); ok = 1;
    count_ls(PRE + 12, cl, ch);
    check_int("R9 recovery precharge", cl, PRE);
    check("R9 hs after recovery", hs_on, 1'b1);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 10 == 0) code = 2'($urandom);
      if (!en && $urandom % 20 == 0) en = 1;
      else if (en && $urandom % 300 == 0) en = 0;
      if (!ok && $urandom % 15 == 0) ok = 1;
      else if (ok && $urandom % 400 == 0) ok = 0;
      if ($urandom % 150 == 0) sr = !sr;
      if ($urandom % 200 == 0) hs_stuck = !hs_stuck;
      if ($urandom % 200 == 0) ls_stuck = !ls_stuck;
    end

    done = 1;
    summary();
    $finish;
  end

endmodule